// File: doc/BRIEF.md
# Hardware-Triggered Continuous ADC Sequencer

This block is the control core of an analog-to-digital converter in a mode where a hardware event sets off conversions that then run on their own. Software controls it through three inputs: an enable level, a write port for the start bit and a write port for the channel register. An external trigger pulse completes the set. The block steps through four states: stopped, idle standby, armed (waiting for a trigger) and converting. It times each conversion with a cycle counter and latches a digital sample of the selected channel into a result register. Each finished conversion raises a one-cycle end-of-conversion pulse.

The trigger only starts the sequence. After the first trigger, conversions follow each other with no gap until software clears the start bit or drops the enable. Three events abort the conversion in flight and start it again from its first cycle: a new trigger, any write to the channel register, or another write of 1 to the start bit. The partial result is discarded. A separate counter tells software when the settling time after enabling has passed.

Top module: `adc_trig_seq`

## Requirements
- R1: While and after reset, `state_o` is 0 (stopped), `eoc_o` is 0, `result_o` is 0 and `stable_o` is 0.
- R2: With `en_i` high, the stopped state moves to standby (`state_o`=1) on the next edge. With `en_i` low, every state returns to stopped on the next edge and the start bit is cleared.
- R3: `stable_o` goes high once `en_i` has been sampled high on STAB_CYCLES consecutive edges. It drops on the edge after `en_i` is sampled low.
- R4: Writing 1 to the start bit in standby moves the block to armed (`state_o`=2). No conversion starts and no `eoc_o` is raised until a trigger arrives.
- R5: A trigger while armed moves the block to converting (`state_o`=3) on the current channel. A trigger while stopped or in standby has no effect.
- R6: A conversion lasts CONV_CYCLES cycles, counted from the cycle after the start edge. On the edge that ends its last cycle, `result_o` takes the selected channel's field of `sample_i` (channel k at bits k*SAMPLE_W and up) as it was in that last cycle, `result_ch_o` takes the channel number, and `eoc_o` is high for exactly the following cycle.
- R7: After a conversion completes, the next conversion on the same channel begins at once, so the next `eoc_o` comes exactly CONV_CYCLES cycles later with no further trigger.
- R8: A trigger during a conversion aborts it and restarts it at cycle one. The aborted conversion produces no result and no `eoc_o`.
- R9: Any channel write during a conversion aborts it, even a write of the same value. Conversion restarts on the channel just written.
- R10: Writing 1 to the start bit during a conversion aborts it and restarts it, with no result from the aborted conversion.
- R11: Writing 0 to the start bit during a conversion aborts it and returns the block to standby with no `eoc_o`. The block stays enabled, and `stable_o` stays high.
- R12: Abort events that fall in the same cycle cause a single restart that uses the newly written channel. An abort in the last conversion cycle wins over completion.
- R13: A write of 1 to the start bit while stopped is ignored, and the block stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable level |
| start_wr_i | input | 1 | Write strobe for the start bit |
| start_wdata_i | input | 1 | Value written to the start bit |
| ch_wr_i | input | 1 | Write strobe for the channel register |
| ch_wdata_i | input | CH_W | Channel value written |
| hw_trig_i | input | 1 | Hardware trigger pulse |
| sample_i | input | NUM_CH*SAMPLE_W | Digital samples, one field per channel |
| state_o | output | 2 | 0 stopped, 1 standby, 2 armed, 3 converting |
| stable_o | output | 1 | Settling time since enable has elapsed |
| result_o | output | SAMPLE_W | Last completed conversion result |
| result_ch_o | output | CH_W | Channel of the last result |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
The bench aborts conversions at several depths. One abort falls in the very last conversion cycle. A design that let completion win there would emit a stale result, and a design that did not reset the counter would emit the next pulse early. It also writes the same channel value again to prove that the write still restarts the conversion, and it fires all three abort sources in one cycle to catch a double restart or a capture from the old channel. The sample bus changes every cycle, so a capture taken one cycle early or late shows up as a wrong value. Triggers sent while stopped or in standby must leave the state and the pulse output untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_STOP    = 2'd0,
      ST_STANDBY = 2'd1,
      ST_ARMED   = 2'd2,
      ST_CONV    = 2'd3
   } seq_state_e;

   function automatic int ch_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       start_wr_i,
   input  logic       start_wdata_i,
   input  logic       ch_wr_i,
   input  logic       hw_trig_i,
   output seq_state_e state_o,
   output logic       conv_load_o,
   output logic       conv_run_o
);

   seq_state_e state_q, state_d;
   logic       set_start, clr_start, restart_ev;

   assign set_start  = start_wr_i & start_wdata_i;
   assign clr_start  = start_wr_i & ~start_wdata_i;
   assign restart_ev = hw_trig_i | ch_wr_i | set_start;

   always_comb begin
      state_d     = state_q;
      conv_load_o = 1'b0;
      conv_run_o  = 1'b0;
      if (!en_i) begin
         state_d = ST_STOP;
      end else begin
         unique case (state_q)
            ST_STOP:    state_d = ST_STANDBY;
            ST_STANDBY: if (set_start) state_d = ST_ARMED;
            ST_ARMED: begin
               if (clr_start) begin
                  state_d = ST_STANDBY;
               end else if (hw_trig_i) begin
                  state_d     = ST_CONV;
                  conv_load_o = 1'b1;
               end
            end
            ST_CONV: begin
               if (clr_start)       state_d     = ST_STANDBY;
               else if (restart_ev) conv_load_o = 1'b1;
               else                 conv_run_o  = 1'b1;
            end
            default: state_d = ST_STOP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_STOP;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int CONV_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic done_o
);

   localparam int CNT_W = $clog2(CONV_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ONE;
      end else if (load_i) begin
         cnt_q <= ONE;
      end else if (run_i) begin
         cnt_q <= (cnt_q == LAST) ? ONE : cnt_q + ONE;
      end
   end

   assign done_o = run_i & (cnt_q == LAST);

endmodule

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
   parameter int STAB_CYCLES = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic stable_o
);

   generate
      if (STAB_CYCLES == 0) begin : g_no_wait
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en_i;
         end
         assign stable_o = en_q;
      end else begin : g_count
         localparam int SW = $clog2(STAB_CYCLES + 1);
         localparam logic [SW-1:0] LIMIT = SW'(STAB_CYCLES);
         logic [SW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!en_i)          cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + SW'(1);
         end
         assign stable_o = (cnt_q == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
   parameter int NUM_CH   = 4,
   parameter int SAMPLE_W = 10,
   parameter int CH_W     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       done_i,
   input  logic [CH_W-1:0]            ch_i,
   input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
   output logic [SAMPLE_W-1:0]        result_o,
   output logic [CH_W-1:0]            result_ch_o,
   output logic                       eoc_o
);

   localparam int LANES = 1 << CH_W;

   logic [SAMPLE_W-1:0] lane [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         if (g < NUM_CH) begin : g_real
            assign lane[g] = sample_i[g*SAMPLE_W +: SAMPLE_W];
         end else begin : g_pad
            assign lane[g] = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o    <= '0;
         result_ch_o <= '0;
         eoc_o       <= 1'b0;
      end else begin
         eoc_o <= done_i;
         if (done_i) begin
            result_o    <= lane[ch_i];
            result_ch_o <= ch_i;
         end
      end
   end

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SAMPLE_W    = 10,
   parameter int CONV_CYCLES = 8,
   parameter int STAB_CYCLES = 125,
   parameter int CH_W        = ch_width(NUM_CH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en_i,
   input  logic                       start_wr_i,
   input  logic                       start_wdata_i,
   input  logic                       ch_wr_i,
   input  logic [CH_W-1:0]            ch_wdata_i,
   input  logic                       hw_trig_i,
   input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
   output logic [1:0]                 state_o,
   output logic                       stable_o,
   output logic [SAMPLE_W-1:0]        result_o,
   output logic [CH_W-1:0]            result_ch_o,
   output logic                       eoc_o
);

   generate
      if (CONV_CYCLES < 2) begin : g_bad_conv
         $error("CONV_CYCLES must be at least 2");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (SAMPLE_W < 1) begin : g_bad_w
         $error("SAMPLE_W must be at least 1");
      end
      if (STAB_CYCLES < 0) begin : g_bad_stab
         $error("STAB_CYCLES must not be negative");
      end
   endgenerate

   seq_state_e      state;
   logic            conv_load, conv_run, conv_done;
   logic [CH_W-1:0] ch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ch_q <= '0;
      else if (ch_wr_i) ch_q <= ch_wdata_i;
   end

   adc_seq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_i),
      .start_wr_i   (start_wr_i),
      .start_wdata_i(start_wdata_i),
      .ch_wr_i      (ch_wr_i),
      .hw_trig_i    (hw_trig_i),
      .state_o      (state),
      .conv_load_o  (conv_load),
      .conv_run_o   (conv_run)
   );

   adc_seq_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(conv_load),
      .run_i (conv_run),
      .done_o(conv_done)
   );

   adc_seq_settle #(.STAB_CYCLES(STAB_CYCLES)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_i),
      .stable_o(stable_o)
   );

   adc_seq_capture #(
      .NUM_CH  (NUM_CH),
      .SAMPLE_W(SAMPLE_W),
      .CH_W    (CH_W)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (conv_done),
      .ch_i       (ch_q),
      .sample_i   (sample_i),
      .result_o   (result_o),
      .result_ch_o(result_ch_o),
      .eoc_o      (eoc_o)
   );

   assign state_o = state;

endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_i,
   input logic       start_wr_i,
   input logic       start_wdata_i,
   input logic       hw_trig_i,
   input logic [1:0] state_o,
   input logic       eoc_o
);

   p_eoc_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |=> !eoc_o);

   p_disable_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (state_o == 2'd0));

   p_standby_trig_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && state_o == 2'd1 && hw_trig_i) |=> (state_o != 2'd3));

   p_armed_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && state_o == 2'd2 && !hw_trig_i && !start_wr_i) |=> (state_o == 2'd2 && !eoc_o));

   p_retrig_no_eoc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && state_o == 2'd3 && hw_trig_i) |=> !eoc_o);

   p_clear_to_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && state_o == 2'd3 && start_wr_i && !start_wdata_i) |=> (state_o == 2'd1 && !eoc_o));

endmodule

bind adc_trig_seq adc_trig_seq_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .en_i         (en_i),
   .start_wr_i   (start_wr_i),
   .start_wdata_i(start_wdata_i),
   .hw_trig_i    (hw_trig_i),
   .state_o      (state_o),
   .eoc_o        (eoc_o)
);

// File: tb/adc_trig_seq_tb_top.sv
module adc_trig_seq_tb_top;

   localparam int NCH  = 4;
   localparam int W    = 10;
   localparam int C    = 8;
   localparam int S    = 125;
   localparam int CW   = 2;

   typedef struct {
      int          at;
      int          ch;
      logic [W-1:0] val;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0, swr = 1'b0, sdat = 1'b0, cwr = 1'b0, trig = 1'b0;
   logic [CW-1:0]     cdat = '0;
   logic [NCH*W-1:0]  sample = '0;
   logic [1:0]        state;
   logic              stable, eoc;
   logic [W-1:0]      result;
   logic [CW-1:0]     result_ch;

   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   int   t0 = 0;
   int   cur_ch = 0;
   exp_t sb[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_trig_seq #(
      .NUM_CH(NCH), .SAMPLE_W(W), .CONV_CYCLES(C), .STAB_CYCLES(S)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .start_wr_i(swr), .start_wdata_i(sdat),
      .ch_wr_i(cwr), .ch_wdata_i(cdat), .hw_trig_i(trig), .sample_i(sample),
      .state_o(state), .stable_o(stable), .result_o(result),
      .result_ch_o(result_ch), .eoc_o(eoc)
   );

   function automatic logic [W-1:0] smp(input int c, input int g);
      int v;
      v = c * 37 + g * 101 + 5;
      return v[W-1:0];
   endfunction

   always @(negedge clk) begin
      for (int g = 0; g < NCH; g++) sample[g*W +: W] = smp(cyc, g);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every end-of-conversion pulse
   always @(negedge clk) begin
      if (rst_n && eoc) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R8 unexpected eoc", cyc, -1);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(cyc == e.at, "R7 eoc cycle", cyc, e.at);
            chk(result == e.val, "R6 result value", int'(result), int'(e.val));
            chk(int'(result_ch) == e.ch, "R6 result channel", int'(result_ch), e.ch);
         end
      end
   end

   task automatic push_n(input int n);
      for (int k = 1; k <= n; k++) begin
         exp_t e;
         e.at  = t0 + k * C;
         e.ch  = cur_ch;
         e.val = smp(t0 + k * C - 1, cur_ch);
         sb.push_back(e);
      end
   endtask

   task automatic go_to(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   // kind: 0 trigger, 1 channel write, 2 start rewrite, 3 all three
   task automatic disturb(input int n, input int m, input int kind, input int nch);
      go_to(t0 + n * C + m - 1);
      trig = (kind == 0 || kind == 3);
      cwr  = (kind == 1 || kind == 3);
      cdat = CW'(nch);
      swr  = (kind == 2 || kind == 3);
      sdat = swr;
      t0   = cyc + 1;
      if (cwr) cur_ch = nch;
      @(negedge clk);
      trig = 0; cwr = 0; swr = 0; sdat = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n0;
      repeat (3) @(negedge clk);
      chk(state == 2'd0 && !eoc && result == '0 && !stable, "R1 reset state", int'(state), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(state == 2'd0 && !eoc && !stable, "R1 after release", int'(state), 0);

      // stopped: trigger and start write ignored
      trig = 1; @(negedge clk); trig = 0; @(negedge clk);
      chk(state == 2'd0, "R5 trigger while stopped", int'(state), 0);
      swr = 1; sdat = 1; @(negedge clk); swr = 0; sdat = 0; @(negedge clk);
      chk(state == 2'd0, "R13 start write while stopped", int'(state), 0);

      // enable and settling
      en = 1; n0 = cyc;
      @(negedge clk);
      chk(state == 2'd1, "R2 stop to standby", int'(state), 1);
      go_to(n0 + S - 1);
      chk(!stable, "R3 stable early", int'(stable), 0);
      go_to(n0 + S);
      chk(stable, "R3 stable on time", int'(stable), 1);

      trig = 1; @(negedge clk); trig = 0; @(negedge clk);
      chk(state == 2'd1, "R5 trigger in standby", int'(state), 1);

      swr = 1; sdat = 1; @(negedge clk); swr = 0; sdat = 0;
      chk(state == 2'd2, "R4 armed", int'(state), 2);
      repeat (20) @(negedge clk);
      chk(state == 2'd2 && !eoc, "R4 armed waits for trigger", int'(state), 2);

      cwr = 1; cdat = 2'd1; @(negedge clk); cwr = 0; cur_ch = 1;

      trig = 1; t0 = cyc + 1; push_n(3);
      @(negedge clk); trig = 0;
      chk(state == 2'd3, "R5 trigger starts conversion", int'(state), 3);

      disturb(3, 3, 0, cur_ch); push_n(2);        // R8 retrigger
      disturb(2, 5, 1, cur_ch); push_n(2);        // R9 same-value channel write
      disturb(2, 2, 1, 2);      push_n(2);        // R9 new channel
      disturb(2, 4, 2, cur_ch); push_n(2);        // R10 start rewrite
      disturb(2, C, 0, cur_ch); push_n(2);        // R12 abort on final cycle
      disturb(2, 6, 3, 3);      push_n(2);        // R12 coincident events

      go_to(t0 + 2 * C + 2);
      swr = 1; sdat = 0; @(negedge clk); swr = 0;
      chk(state == 2'd1, "R11 clear start to standby", int'(state), 1);
      repeat (2 * C) @(negedge clk);
      chk(state == 2'd1 && stable, "R11 stays enabled and idle", int'(state), 1);

      swr = 1; sdat = 1; @(negedge clk); swr = 0; sdat = 0;
      trig = 1; t0 = cyc + 1; push_n(1);
      @(negedge clk); trig = 0;
      go_to(t0 + C + 1);
      en = 0; @(negedge clk);
      chk(state == 2'd0, "R2 disable stops conversion", int'(state), 0);
      chk(!stable, "R3 stable clears", int'(stable), 0);
      repeat (3 * C) @(negedge clk);
      chk(sb.size() == 0, "R7 all expected results seen", sb.size(), 0);
      chk(state == 2'd0, "R2 remains stopped", int'(state), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule